// File: doc/BRIEF.md
# Timed-Sequence Protected Configuration Register

This block holds a configuration field that ordinary software writes cannot change by accident. The field changes only through a two-step sequence on a simple register write port. The first write is the arming write. It sets a change-enable bit and must write zero to every other bit of the register. That write opens a window that lasts a fixed number of clock cycles. If a second write with change-enable cleared arrives while the window is open, its payload bits replace the field and the window closes. A late write has no effect. So does a malformed arming write, or a window that is left to expire.

A second register at the other address guards a one-shot action in the same way. Setting both its arm bit and its action bit opens an action window. A write inside that window with the action bit set and the arm bit cleared requests the action. The action output then asserts a fixed number of cycles later. A write of all zeros to that register releases the action at once. Both registers can be read back combinationally. In each read word, the change-enable or arm bit shows whether the window is open.

Top module: `prot_cfg_reg`

## Requirements
- R1: After reset, `field_o` equals `FIELD_RST` (zero by default), both windows are closed, `act_o` is low, and both read words are zero.
- R2: A write to select 0 whose bit `CE_BIT` (bit 7) is 1 and whose other bits are all zero opens the window from the next cycle. It does not change `field_o`.
- R3: A write to select 0 with bit `CE_BIT` at 0 is accepted if it is sampled on any of the `WIN_CYC` (4) clock edges after the arming edge. On acceptance, `field_o` takes the write data with bit `CE_BIT` removed (bits 6:0 by default), and the window closes.
- R4: If `WIN_CYC` edges pass without a write, the window closes. A write with bit `CE_BIT` at 0 while the window is closed leaves `field_o` unchanged.
- R5: A write to select 0 with bit `CE_BIT` at 1 and any other bit nonzero never opens the window. If the window is already open, that write closes it without changing `field_o`.
- R6: The exact arming pattern written while the window is open restarts the full `WIN_CYC`-edge window.
- R7: With `rd_sel_i` at 0, `rd_data_o` returns the field at its bit positions and bit `CE_BIT` equal to the window state. With `rd_sel_i` at 1, bit `ACT_BIT` (0) holds the action request, bit `ARM_BIT` (1) holds the action window state, and all other bits are zero.
- R8: A write to select 1 with bits `ARM_BIT` and `ACT_BIT` both 1 opens the action window. A write with `ACT_BIT` at 1 and `ARM_BIT` at 0 within `WIN_CYC` edges sets the action request and closes the action window. Later such writes are ignored.
- R9: `act_o` rises exactly `ACT_DELAY` (3) clock edges after the edge that sets the action request, and stays high while the request holds.
- R10: A write of zero to both bits `ARM_BIT` and `ACT_BIT` at select 1 clears the request, drops `act_o` and closes the action window on that edge.
- R11: Writes to one select leave the other register's window and contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wr_sel_i | input | 1 | Write target: 0 configuration, 1 action |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 1 | Read target: 0 configuration, 1 action |
| rd_data_o | output | DATA_W | Combinational read word |
| field_o | output | DATA_W-1 | Current protected field |
| win_open_o | output | 1 | Configuration window open |
| act_win_open_o | output | 1 | Action window open |
| act_o | output | 1 | Delayed action output |

## Verification
The bench uses the defaults: an 8-bit register with change-enable at bit 7, a four-edge window and a three-cycle action delay. At that size all 128 field payloads and all 127 malformed arming patterns can be driven one by one. The second write of each sequence is placed at every offset from one to six edges after the arming write, so both the last accepted edge and the first rejected edge are exercised for each register. A three-cycle delay also makes it practical to observe `act_o` on every cycle between the request and its rise.

// File: rtl/pcr_pkg.sv
`timescale 1ns/1ps
package pcr_pkg;
  typedef enum logic {
    SEL_CFG = 1'b0,
    SEL_ACT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/pcr_window.sv
`timescale 1ns/1ps
module pcr_window #(
  parameter int unsigned WIN_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic close_i,
  output logic open_o
);
  localparam int unsigned CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYC);

  logic [CNT_W-1:0] cnt_q;

  // arm wins over close so a re-arm in the window restarts it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (arm_i)             cnt_q <= CNT_LOAD;
    else if (close_i)           cnt_q <= '0;
    else if (cnt_q != '0)       cnt_q <= cnt_q - CNT_W'(1);
  end

  assign open_o = (cnt_q != '0);

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LOAD);
  p_arm_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> open_o);
  p_close_shuts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_i && !arm_i) |=> !open_o);
endmodule

// File: rtl/pcr_cfg_field.sv
`timescale 1ns/1ps
module pcr_cfg_field
  import pcr_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CE_BIT  = 7,
  parameter int unsigned WIN_CYC = 4,
  parameter logic [DATA_W-2:0] FIELD_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-2:0] field_o,
  output logic              open_o,
  output logic [DATA_W-1:0] rd_word_o
);
  localparam int unsigned FIELD_W = DATA_W - 1;

  logic [FIELD_W-1:0] field_q;
  logic [FIELD_W-1:0] wr_rest;
  logic hit, ce, arm, commit, abort;

  // split write data around the change-enable bit, rebuild read word
  for (genvar g = 0; g < DATA_W; g++) begin : g_map
    if (g < CE_BIT) begin : g_lo
      assign wr_rest[g]   = wr_data_i[g];
      assign rd_word_o[g] = field_q[g];
    end else if (g > CE_BIT) begin : g_hi
      assign wr_rest[g-1] = wr_data_i[g];
      assign rd_word_o[g] = field_q[g-1];
    end else begin : g_ce
      assign rd_word_o[g] = open_o;
    end
  end

  assign hit    = wr_en_i && (wr_sel_i == SEL_CFG);
  assign ce     = wr_data_i[CE_BIT];
  assign arm    = hit && ce && (wr_rest == '0);
  assign abort  = hit && ce && (wr_rest != '0);
  assign commit = hit && !ce && open_o;

  pcr_window #(.WIN_CYC(WIN_CYC)) i_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .close_i(commit || abort),
    .open_o (open_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     field_q <= FIELD_RST;
    else if (commit) field_q <= wr_rest;
  end

  assign field_o = field_q;

  p_field_guard_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (wr_sel_i == SEL_CFG) && !wr_data_i[CE_BIT]) |=> $stable(field_o));
  p_bad_arm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort && !open_o) |=> !open_o);
endmodule

// File: rtl/pcr_action.sv
`timescale 1ns/1ps
module pcr_action
  import pcr_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ARM_BIT   = 1,
  parameter int unsigned ACT_BIT   = 0,
  parameter int unsigned WIN_CYC   = 4,
  parameter int unsigned ACT_DELAY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              open_o,
  output logic              act_o,
  output logic [DATA_W-1:0] rd_word_o
);
  localparam int unsigned DLY_W = (ACT_DELAY > 0) ? $clog2(ACT_DELAY + 1) : 1;
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(ACT_DELAY);

  logic hit, a_bit, x_bit, arm, commit, clr, stray;
  logic req_q;
  logic [DLY_W-1:0] dly_q;

  assign hit    = wr_en_i && (wr_sel_i == SEL_ACT);
  assign a_bit  = wr_data_i[ARM_BIT];
  assign x_bit  = wr_data_i[ACT_BIT];
  assign arm    = hit && a_bit && x_bit;
  assign commit = hit && !a_bit && x_bit && open_o;
  assign clr    = hit && !a_bit && !x_bit;
  assign stray  = hit && a_bit && !x_bit;

  pcr_window #(.WIN_CYC(WIN_CYC)) i_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .close_i(commit || clr || stray),
    .open_o (open_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      dly_q <= '0;
    end else if (clr) begin
      req_q <= 1'b0;
      dly_q <= '0;
    end else if (commit && !req_q) begin
      req_q <= 1'b1;
      dly_q <= DLY_LOAD;
    end else if (req_q && (dly_q != '0)) begin
      dly_q <= dly_q - DLY_W'(1);
    end
  end

  assign act_o = req_q && (dly_q == '0);

  always_comb begin
    rd_word_o          = '0;
    rd_word_o[ARM_BIT] = open_o;
    rd_word_o[ACT_BIT] = req_q;
  end

  p_act_needs_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> req_q);
  p_act_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_o) |-> $past(req_q));
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (!act_o && !req_q && !open_o));
endmodule

// File: rtl/prot_cfg_reg.sv
`timescale 1ns/1ps
module prot_cfg_reg
  import pcr_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CE_BIT    = 7,
  parameter int unsigned ARM_BIT   = 1,
  parameter int unsigned ACT_BIT   = 0,
  parameter int unsigned WIN_CYC   = 4,
  parameter int unsigned ACT_DELAY = 3,
  parameter logic [DATA_W-2:0] FIELD_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-2:0] field_o,
  output logic              win_open_o,
  output logic              act_win_open_o,
  output logic              act_o
);
  logic [DATA_W-1:0] cfg_word, act_word;

  pcr_cfg_field #(
    .DATA_W   (DATA_W),
    .CE_BIT   (CE_BIT),
    .WIN_CYC  (WIN_CYC),
    .FIELD_RST(FIELD_RST)
  ) i_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .field_o  (field_o),
    .open_o   (win_open_o),
    .rd_word_o(cfg_word)
  );

  pcr_action #(
    .DATA_W   (DATA_W),
    .ARM_BIT  (ARM_BIT),
    .ACT_BIT  (ACT_BIT),
    .WIN_CYC  (WIN_CYC),
    .ACT_DELAY(ACT_DELAY)
  ) i_act (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .open_o   (act_win_open_o),
    .act_o    (act_o),
    .rd_word_o(act_word)
  );

  assign rd_data_o = (rd_sel_i == SEL_ACT) ? act_word : cfg_word;

  p_read_ce_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == SEL_CFG) |-> (rd_data_o[CE_BIT] == win_open_o));
  p_isolate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_sel_i == SEL_ACT)) |=> $stable(field_o));
endmodule

// File: tb/test_prot_cfg_reg.sv
`timescale 1ns/1ps
module test_prot_cfg_reg;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic [6:0] field;
  logic       win_open, act_win_open, act;

  int total = 0;
  int bad = 0;
  logic [6:0] ef = '0;

  always #4 clk = ~clk;

  prot_cfg_reg i_prot_cfg_reg (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en),
    .wr_sel_i      (wr_sel),
    .wr_data_i     (wr_data),
    .rd_sel_i      (rd_sel),
    .rd_data_o     (rd_data),
    .field_o       (field),
    .win_open_o    (win_open),
    .act_win_open_o(act_win_open),
    .act_o         (act)
  );

  task automatic chk(input string tag, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic sel, output int val);
    rd_sel = sel; #1; val = int'(rd_data);
  endtask

  initial begin
    #1600000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r;
    idle(2);
    // R1 reset state
    chk("R1 field", int'(field), 0);
    chk("R1 win", int'(win_open), 0);
    chk("R1 act_win", int'(act_win_open), 0);
    chk("R1 act", int'(act), 0);
    rd(1'b0, r); chk("R1 rd cfg", r, 0);
    rd(1'b1, r); chk("R1 rd act", r, 0);
    rst_ni = 1'b1;
    idle(1);

    // R2/R3/R4 second-write offset sweep
    for (int d = 1; d <= 6; d++) begin
      logic [6:0] v = 7'((d * 37 + 5) & 127);
      wr(1'b0, 8'h80);
      chk("R2 open", int'(win_open), 1);
      chk("R2 field kept", int'(field), int'(ef));
      idle(d - 1);
      chk("R4 window state", int'(win_open), (d <= 4) ? 1 : 0);
      wr(1'b0, {1'b0, v});
      if (d <= 4) ef = v;
      chk((d <= 4) ? "R3 accept" : "R4 late reject", int'(field), int'(ef));
      chk("R3 closed", int'(win_open), 0);
    end

    // R3/R7 all payloads
    for (int v = 0; v < 128; v++) begin
      wr(1'b0, 8'h80);
      idle(v % 4);
      rd(1'b0, r); chk("R7 rd ce open", (r >> 7) & 1, 1);
      wr(1'b0, 8'(v));
      ef = 7'(v);
      chk("R3 payload", int'(field), v);
      rd(1'b0, r); chk("R7 rd field", r, v);
    end

    // R5 malformed arming patterns
    for (int p = 1; p < 128; p++) begin
      wr(1'b0, 8'(p | 128));
      chk("R5 no open", int'(win_open), 0);
      chk("R5 field kept", int'(field), int'(ef));
      if (p % 16 == 0) begin
        wr(1'b0, 8'(p ^ 8'h55));
        chk("R4 closed write ignored", int'(field), int'(ef));
      end
    end

    // R5 malformed arm inside window
    wr(1'b0, 8'h80);
    wr(1'b0, 8'h85);
    chk("R5 abort closes", int'(win_open), 0);
    chk("R5 abort field", int'(field), int'(ef));
    wr(1'b0, 8'h2a);
    chk("R5 after abort", int'(field), int'(ef));

    // R6 re-arm
    wr(1'b0, 8'h80);
    idle(3);
    wr(1'b0, 8'h80);
    chk("R6 field kept", int'(field), int'(ef));
    idle(3);
    chk("R6 still open", int'(win_open), 1);
    wr(1'b0, 8'h3c);
    ef = 7'h3c;
    chk("R6 accept", int'(field), 'h3c);
    wr(1'b0, 8'h80);
    idle(3);
    wr(1'b0, 8'h80);
    idle(4);
    chk("R6 expires", int'(win_open), 0);

    // R8 action offset sweep
    for (int d = 1; d <= 6; d++) begin
      wr(1'b1, 8'h03);
      chk("R8 act window", int'(act_win_open), 1);
      rd(1'b1, r); chk("R7 rd act open", r, 2);
      idle(d - 1);
      wr(1'b1, 8'h01);
      rd(1'b1, r); chk("R8 request", r, (d <= 4) ? 1 : 0);
      chk("R8 window closed", int'(act_win_open), 0);
      wr(1'b1, 8'h00);
    end

    // R9 delay, R10 clear
    wr(1'b1, 8'h03);
    wr(1'b1, 8'h01);
    for (int k = 0; k <= 5; k++) begin
      chk("R9 delay", int'(act), (k >= 3) ? 1 : 0);
      idle(1);
    end
    wr(1'b1, 8'h00);
    chk("R10 act cleared", int'(act), 0);
    rd(1'b1, r); chk("R10 req cleared", r, 0);
    wr(1'b1, 8'h01);
    idle(4);
    chk("R10 no window ignored", int'(act), 0);
    rd(1'b1, r); chk("R10 rd ignored", r, 0);
    wr(1'b1, 8'h03);
    wr(1'b1, 8'h00);
    chk("R10 clear closes", int'(act_win_open), 0);

    // R11 isolation
    wr(1'b0, 8'h80);
    wr(1'b1, 8'h03);
    chk("R11 cfg win kept", int'(win_open), 1);
    chk("R11 field kept", int'(field), int'(ef));
    wr(1'b0, 8'h11);
    ef = 7'h11;
    chk("R11 cfg accept", int'(field), 'h11);
    chk("R11 act win kept", int'(act_win_open), 1);
    wr(1'b1, 8'h01);
    rd(1'b1, r); chk("R11 act req", r, 1);
    chk("R11 field after act", int'(field), 'h11);
    wr(1'b1, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule